// File: doc/BRIEF.md
# Control-Register Port Write Sequencer

This block turns one write request from a local command interface into the handshake sequence that a PHY's internal control-register port expects. The port has a 32-bit control word made of a 16-bit data-in field and a set of strobes, and a 32-bit status word made of an acknowledge bit and a 16-bit data-out field. A write is delivered as three full four-phase handshakes in a fixed order: the address is captured, then the data is captured, then the write is committed. In each handshake the strobe is raised with the value on data-in, the acknowledge must rise, the strobe drops with data-in held, and the acknowledge must fall.

Each wait for an acknowledge edge is bounded. The bound is a number of poll intervals, and each interval is a number of clock cycles, so the bound tracks the system clock. When a wait expires, the remaining phases are skipped, all strobes go low and a one-cycle error pulse is raised together with the value that was being sent. A clean finish gives a one-cycle done pulse. The block also keeps the data-out field as it stood when the acknowledge was last seen high.

Top module: `crport_hs_master`

## Requirements
- R1: After a synchronous reset the control word is all zero, `req_ready` is high and neither `done_pulse` nor `err_pulse` is high.
- R2: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low the next cycle and stays low while any strobe is high.
- R3: An accepted write raises strobes in this order: capture-address (control bit 0), then capture-data (control bit 1), then commit-write (control bit 19). Each is raised exactly once. The read strobe (control bit 18) is never raised.
- R4: Data-in (control bits [17:2]) carries the request address during the capture-address phase and the request data during the other two phases. It does not change while a strobe is high.
- R5: The value for each phase is on data-in one cycle before that phase's strobe rises, with no strobe high in that cycle.
- R6: The strobe goes low in the cycle after the acknowledge (status bit 0) is sampled high. The next phase starts only after the acknowledge is sampled low.
- R7: At most one strobe is high in any cycle.
- R8: A write in which all three handshakes complete gives exactly one `done_pulse` and no `err_pulse`. The pulse comes in the cycle after the acknowledge of the commit phase is sampled low, with the control word back at zero.
- R9: If the acknowledge is not sampled high within POLL_LIMIT × CYC_PER_POLL cycles of a strobe rising, the strobe stays high for exactly that many cycles. The block then raises one `err_pulse` with the control word at zero and skips the remaining phases. An acknowledge that arrives on the last cycle of that window still completes the phase.
- R10: If the acknowledge is not sampled low within POLL_LIMIT × CYC_PER_POLL cycles after the strobe drops, the block raises one `err_pulse` with the control word at zero and skips the remaining phases.
- R11: When `err_pulse` is high, `err_value` holds the value of the aborted phase: the address for the capture-address phase, and the data for the other two phases.
- R12: `rd_data` takes the data-out field (status bits [16:1]) in the cycle the acknowledge is sampled high. After a completed write it therefore holds the value returned during the commit phase.
- R13: A synchronous reset during a write drops it. All strobes go low, the block is idle one cycle later, and no done or error pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 16 | Target register address |
| req_data | input | 16 | Value to write |
| done_pulse | output | 1 | One-cycle pulse: write completed |
| err_pulse | output | 1 | One-cycle pulse: write aborted on a timeout |
| err_value | output | 16 | Value being sent when the abort happened |
| rd_data | output | 16 | Data-out field captured at the last acknowledge rise |
| port_ctrl | output | 32 | Control word to the port: strobes at bits 0, 1, 18 and 19, data-in at [17:2] |
| port_stat | input | 32 | Status word from the port: acknowledge at bit 0, data-out at [16:1] |

## Verification
Random addresses and data are sent through a responder whose rise and fall delays are drawn at random. This shows that the phase order, the data-in contents and the setup cycle do not depend on how fast the far side answers. Directed cases use all-zero and all-one values, so that any swap of address and data, or a wrong field position, becomes visible. Other directed cases make the responder hang its rise and then its fall on each of the three phases, which separates the two timeout paths and gives the per-phase `err_value`. Responder delays of exactly one cycle inside the timeout window check where the window ends, and a reset in the middle of a write checks that the write is dropped cleanly.

// File: rtl/crport_pkg.sv
package crport_pkg;
  localparam int VAL_W        = 16;
  localparam int CTRL_W       = 32;
  localparam int STAT_W       = 32;
  // control word layout, decoded by the port
  localparam int BIT_CAP_ADDR = 0;
  localparam int BIT_CAP_DATA = 1;
  localparam int DIN_LSB      = 2;
  localparam int BIT_RD       = 18;
  localparam int BIT_WR       = 19;
  // status word layout
  localparam int BIT_ACK      = 0;
  localparam int DOUT_LSB     = 1;
  localparam int N_STB        = 3;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SETUP, ST_WAIT_HI, ST_WAIT_LO
  } seq_state_e;

  // order is behaviour: address, data, commit
  typedef enum logic [1:0] {
    PH_ADDR   = 2'd0,
    PH_DATA   = 2'd1,
    PH_COMMIT = 2'd2
  } seq_phase_e;
endpackage

// File: rtl/crport_wait_timer.sv
module crport_wait_timer #(
  parameter int CYC_PER_POLL = 125,
  parameter int POLL_LIMIT   = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  output logic limit_hit_o
);
  localparam int TW = (CYC_PER_POLL > 1) ? $clog2(CYC_PER_POLL) : 1;
  localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(CYC_PER_POLL - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);

  logic [TW-1:0] tick_q;
  logic [PW-1:0] poll_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      tick_q <= '0;
      poll_q <= '0;
    end else if (en_i) begin
      if (tick_q == TICK_LAST) begin
        tick_q <= '0;
        poll_q <= poll_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  // last cycle of the final poll interval
  assign limit_hit_o = (tick_q == TICK_LAST) && (poll_q == POLL_LAST);
endmodule

// File: rtl/crport_ctrl_word.sv
module crport_ctrl_word
  import crport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_all_i,
  input  logic              ld_din_i,
  input  logic [VAL_W-1:0]  din_i,
  input  logic              stb_set_i,
  input  logic              stb_clr_i,
  input  seq_phase_e        stb_sel_i,
  output logic [CTRL_W-1:0] word_o
);
  logic [VAL_W-1:0] din_q;
  logic [N_STB-1:0] stb_q;

  always_ff @(posedge clk) begin
    if (rst || clr_all_i) begin
      din_q <= '0;
      stb_q <= '0;
    end else begin
      if (ld_din_i) din_q <= din_i;
      if (stb_set_i)      stb_q <= N_STB'(1) << stb_sel_i;
      else if (stb_clr_i) stb_q <= '0;
    end
  end

  for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
    if (b >= DIN_LSB && b < DIN_LSB + VAL_W) begin : g_din
      assign word_o[b] = din_q[b-DIN_LSB];
    end else if (b == BIT_CAP_ADDR) begin : g_ca
      assign word_o[b] = stb_q[PH_ADDR];
    end else if (b == BIT_CAP_DATA) begin : g_cd
      assign word_o[b] = stb_q[PH_DATA];
    end else if (b == BIT_WR) begin : g_wr
      assign word_o[b] = stb_q[PH_COMMIT];
    end else begin : g_zero
      assign word_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/crport_hs_master.sv
module crport_hs_master
  import crport_pkg::*;
#(
  parameter int CYC_PER_POLL = 125,
  parameter int POLL_LIMIT   = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VAL_W-1:0]  req_addr,
  input  logic [VAL_W-1:0]  req_data,
  output logic              done_pulse,
  output logic              err_pulse,
  output logic [VAL_W-1:0]  err_value,
  output logic [VAL_W-1:0]  rd_data,
  output logic [CTRL_W-1:0] port_ctrl,
  input  logic [STAT_W-1:0] port_stat
);
  seq_state_e state_q, state_n;
  seq_phase_e phase_q, phase_n;
  logic [VAL_W-1:0] addr_q, data_q, errv_q, rdat_q, cur_val, din_nxt;
  logic done_q, done_n, err_q, err_n;
  logic ld_din, stb_set, stb_clr, clr_all, tmr_clr, tmr_en, cap_dout;
  logic limit_hit, ack;
  logic unused_stat;

  assign ack         = port_stat[BIT_ACK];
  assign unused_stat = ^{port_stat[STAT_W-1:DOUT_LSB+VAL_W]};
  assign cur_val     = (phase_q == PH_ADDR) ? addr_q : data_q;

  crport_wait_timer #(
    .CYC_PER_POLL(CYC_PER_POLL),
    .POLL_LIMIT  (POLL_LIMIT)
  ) timer_i (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (tmr_clr),
    .en_i       (tmr_en),
    .limit_hit_o(limit_hit)
  );

  crport_ctrl_word word_i (
    .clk      (clk),
    .rst      (rst),
    .clr_all_i(clr_all),
    .ld_din_i (ld_din),
    .din_i    (din_nxt),
    .stb_set_i(stb_set),
    .stb_clr_i(stb_clr),
    .stb_sel_i(phase_q),
    .word_o   (port_ctrl)
  );

  always_comb begin
    state_n  = state_q;
    phase_n  = phase_q;
    done_n   = 1'b0;
    err_n    = 1'b0;
    ld_din   = 1'b0;
    din_nxt  = data_q;
    stb_set  = 1'b0;
    stb_clr  = 1'b0;
    clr_all  = 1'b0;
    tmr_clr  = 1'b0;
    tmr_en   = 1'b0;
    cap_dout = 1'b0;
    case (state_q)
      ST_IDLE: begin
        tmr_clr = 1'b1;
        if (req_valid) begin
          ld_din  = 1'b1;
          din_nxt = req_addr;
          phase_n = PH_ADDR;
          state_n = ST_SETUP;
        end
      end
      ST_SETUP: begin
        stb_set = 1'b1;
        tmr_clr = 1'b1;
        state_n = ST_WAIT_HI;
      end
      ST_WAIT_HI: begin
        if (ack) begin
          stb_clr  = 1'b1;
          cap_dout = 1'b1;
          tmr_clr  = 1'b1;
          state_n  = ST_WAIT_LO;
        end else begin
          tmr_en = 1'b1;
          if (limit_hit) begin
            clr_all = 1'b1;
            err_n   = 1'b1;
            state_n = ST_IDLE;
          end
        end
      end
      ST_WAIT_LO: begin
        if (!ack) begin
          tmr_clr = 1'b1;
          if (phase_q == PH_COMMIT) begin
            clr_all = 1'b1;
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end else begin
            ld_din  = 1'b1;
            din_nxt = data_q;
            phase_n = (phase_q == PH_ADDR) ? PH_DATA : PH_COMMIT;
            state_n = ST_SETUP;
          end
        end else begin
          tmr_en = 1'b1;
          if (limit_hit) begin
            clr_all = 1'b1;
            err_n   = 1'b1;
            state_n = ST_IDLE;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ADDR;
      addr_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      errv_q  <= '0;
      rdat_q  <= '0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      done_q  <= done_n;
      err_q   <= err_n;
      if (state_q == ST_IDLE && req_valid) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
      if (err_n)    errv_q <= cur_val;
      if (cap_dout) rdat_q <= port_stat[DOUT_LSB +: VAL_W];
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign done_pulse = done_q;
  assign err_pulse  = err_q;
  assign err_value  = errv_q;
  assign rd_data    = rdat_q;
endmodule

// File: rtl/crport_hs_master_chk.sv
module crport_hs_master_chk
  import crport_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              done_pulse,
  input logic              err_pulse,
  input logic [CTRL_W-1:0] port_ctrl,
  input logic [STAT_W-1:0] port_stat
);
  logic             stb;
  logic [VAL_W-1:0] din;
  assign stb = port_ctrl[BIT_CAP_ADDR] | port_ctrl[BIT_CAP_DATA] |
               port_ctrl[BIT_RD] | port_ctrl[BIT_WR];
  assign din = port_ctrl[DIN_LSB +: VAL_W];

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({port_ctrl[BIT_WR], port_ctrl[BIT_RD],
              port_ctrl[BIT_CAP_DATA], port_ctrl[BIT_CAP_ADDR]}));

  a_r3_no_read_strobe: assert property (@(posedge clk) disable iff (rst)
    !port_ctrl[BIT_RD]);

  a_r5_din_setup: assert property (@(posedge clk) disable iff (rst)
    (stb && !$past(stb)) |-> (din == $past(din)));

  a_r4_din_hold: assert property (@(posedge clk) disable iff (rst)
    (stb && $past(stb)) |-> $stable(din));

  a_r6_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (stb && port_stat[BIT_ACK]) |=> !stb);

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    stb |-> !req_ready);

  a_r8_single_outcome: assert property (@(posedge clk) disable iff (rst)
    !(done_pulse && err_pulse));

  a_r8_done_clean: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (port_ctrl == '0));

  a_r9_abort_clean: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (port_ctrl == '0));
endmodule

bind crport_hs_master crport_hs_master_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .done_pulse(done_pulse),
  .err_pulse (err_pulse),
  .port_ctrl (port_ctrl),
  .port_stat (port_stat)
);

// File: tb/crport_hs_master_tb_top.sv
module crport_hs_master_tb_top;
  localparam int CPP   = 4;
  localparam int LIM   = 100;
  localparam int NWAIT = CPP * LIM;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0, req_data = '0;
  logic        done_pulse, err_pulse;
  logic [15:0] err_value, rd_data;
  logic [31:0] port_ctrl, port_stat;

  always #4 clk = ~clk;

  crport_hs_master #(.CYC_PER_POLL(CPP), .POLL_LIMIT(LIM)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .done_pulse(done_pulse),
    .err_pulse(err_pulse), .err_value(err_value), .rd_data(rd_data),
    .port_ctrl(port_ctrl), .port_stat(port_stat)
  );

  int n_chk = 0, n_bad = 0;

  // responder configuration and log
  int cfg_d1 = 0, cfg_d2 = 0, cfg_hr = -1, cfg_hf = -1;
  logic rsp_clear = 1'b0;
  logic ack_r = 1'b0;
  logic [15:0] dout_r = '0;
  assign port_stat = {15'b0, dout_r, ack_r};

  logic [3:0]  log_mask [4];
  logic [15:0] log_din  [4];
  logic [15:0] log_prev [4];
  int          log_high [4];
  int          log_lat  [4];
  int nph = 0, n_done = 0, n_err = 0, ready_viol = 0;
  int rs = 0, rcnt = 0, rlat = 0;
  logic [3:0]  prev_stb = '0;
  logic [15:0] prev_din = '0;
  logic [15:0] last_errv = '0;

  initial begin : responder
    forever begin
      @(negedge clk);
      begin
        logic [3:0]  cur;
        logic [15:0] din;
        cur = {port_ctrl[19], port_ctrl[18], port_ctrl[1], port_ctrl[0]};
        din = port_ctrl[17:2];
        if (rsp_clear) begin
          ack_r = 1'b0;
          rs = 0;
        end else begin
          if (cur != 0 && prev_stb == 0 && nph < 4) begin
            log_mask[nph] = cur; log_din[nph] = din; log_prev[nph] = prev_din;
            log_high[nph] = 0;   log_lat[nph] = 0;
            nph++; rs = 1; rcnt = 0;
          end
          if (cur != 0 && nph > 0) log_high[nph-1]++;
          if (cur != 0 && req_ready) ready_viol++;
          case (rs)
            1: if (cfg_hr != nph - 1) begin
                 if (rcnt >= cfg_d1) begin
                   ack_r = 1'b1; dout_r = din ^ 16'hA5A5; rs = 2; rlat = 0;
                 end else rcnt++;
               end
            2: begin
                 rlat++;
                 if (cur == 0) begin log_lat[nph-1] = rlat; rs = 3; rcnt = 0; end
               end
            3: if (cfg_hf != nph - 1) begin
                 if (rcnt >= cfg_d2) begin ack_r = 1'b0; rs = 0; end
                 else rcnt++;
               end
            default: ;
          endcase
        end
        prev_stb = cur;
        prev_din = din;
        if (done_pulse) n_done++;
        if (err_pulse) begin n_err++; last_errv = err_value; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mask(input int p);
    return (p == 0) ? 4'b0001 : (p == 1) ? 4'b0010 : 4'b1000;
  endfunction

  function automatic logic [15:0] exp_din(input int p, input logic [15:0] a,
                                          input logic [15:0] d);
    return (p == 0) ? a : d;
  endfunction

  task automatic clear_rsp();
    @(negedge clk); rsp_clear = 1'b1;
    @(negedge clk); @(negedge clk);
    rsp_clear = 1'b0;
    nph = 0; n_done = 0; n_err = 0; ready_viol = 0;
    cfg_hr = -1; cfg_hf = -1;
  endtask

  task automatic run_txn(input logic [15:0] a, input logic [15:0] d,
                         input int d1, input int d2, input int hr, input int hf);
    int exp_ph;
    cfg_d1 = d1; cfg_d2 = d2; cfg_hr = hr; cfg_hf = hf;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready when idle", 32'(req_ready), 1);
    req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 ready low after accept", 32'(req_ready), 0);
    for (int t = 0; t < 4000 && n_done == 0 && n_err == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    exp_ph = (hr >= 0) ? hr + 1 : (hf >= 0) ? hf + 1 : 3;
    chk(nph == exp_ph, "R3 phase count", 32'(nph), 32'(exp_ph));
    for (int i = 0; i < nph && i < 3; i++) begin
      chk(log_mask[i] == exp_mask(i), "R3 strobe order", 32'(log_mask[i]), 32'(exp_mask(i)));
      chk(log_din[i] == exp_din(i, a, d), "R4 data-in value", 32'(log_din[i]),
          32'(exp_din(i, a, d)));
      chk(log_prev[i] == log_din[i], "R5 data-in set before strobe", 32'(log_prev[i]),
          32'(log_din[i]));
      if (i != hr)
        chk(log_lat[i] == 1, "R6 strobe drop after ack", 32'(log_lat[i]), 1);
    end
    chk(ready_viol == 0, "R2 ready while strobe high", 32'(ready_viol), 0);
    if (hr < 0 && hf < 0) begin
      chk(n_done == 1 && n_err == 0, "R8 one done pulse", 32'(n_done * 16 + n_err), 32'h10);
      chk(rd_data == (d ^ 16'hA5A5), "R12 data-out capture", 32'(rd_data), 32'(d ^ 16'hA5A5));
    end else begin
      if (hr >= 0) begin
        chk(n_err == 1 && n_done == 0, "R9 rise timeout error", 32'(n_done * 16 + n_err), 32'h1);
        chk(log_high[hr] == NWAIT, "R9 timeout window", 32'(log_high[hr]), 32'(NWAIT));
      end else begin
        chk(n_err == 1 && n_done == 0, "R10 fall timeout error", 32'(n_done * 16 + n_err), 32'h1);
      end
      chk(last_errv == exp_din(hr >= 0 ? hr : hf, a, d), "R11 error value",
          32'(last_errv), 32'(exp_din(hr >= 0 ? hr : hf, a, d)));
      chk(port_ctrl == 32'h0, "R9 strobes low after abort", port_ctrl, 0);
    end
    clear_rsp();
  endtask

  bit finished = 1'b0;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog act=%h exp=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(port_ctrl == 32'h0, "R1 control word zero", port_ctrl, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    chk(!done_pulse && !err_pulse, "R1 no pulses", {done_pulse, err_pulse}, 0);

    // directed values, fastest responder
    run_txn(16'h0000, 16'hFFFF, 0, 0, -1, -1);
    run_txn(16'hFFFF, 16'h0000, 0, 0, -1, -1);
    run_txn(16'h0015, 16'hA409, 2, 3, -1, -1);
    // R9 boundary: acknowledge rises on last cycle of window
    run_txn(16'h1234, 16'h5678, NWAIT - 1, 0, -1, -1);
    // R10 boundary: acknowledge falls on last cycle of window
    run_txn(16'h4321, 16'h8765, 0, NWAIT - 2, -1, -1);

    // random traffic
    for (int k = 0; k < 30; k++)
      run_txn(16'($urandom), 16'($urandom), int'($urandom % 5), int'($urandom % 5), -1, -1);

    // timeouts on every phase, both edges (R9, R10, R11)
    for (int p = 0; p < 3; p++) begin
      run_txn(16'($urandom), 16'($urandom), 1, 1, p, -1);
      run_txn(16'($urandom), 16'($urandom), 1, 1, -1, p);
    end

    // R13 reset in the middle of a write
    cfg_d1 = 0; cfg_d2 = 0; cfg_hr = 1; cfg_hf = -1;
    @(negedge clk);
    req_addr = 16'hBEEF; req_data = 16'hCAFE; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(port_ctrl[1] == 1'b1, "R13 write in flight", 32'(port_ctrl[1]), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(port_ctrl == 32'h0, "R13 strobes low on reset", port_ctrl, 0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R13 idle after reset", 32'(req_ready), 1);
    repeat (NWAIT + 50) @(negedge clk);
    chk(n_done == 0 && n_err == 0, "R13 no pulse after reset", 32'(n_done * 16 + n_err), 0);
    clear_rsp();
    run_txn(16'h0A0A, 16'h5050, 1, 2, -1, -1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule